// File: doc/BRIEF.md
# Mixed-Length Instruction Parcel Sequencer

This block sits at the front of a processor that runs 60-bit instruction words. Each word carries two to four instructions. Every instruction is either 15 or 30 bits long, and no instruction runs from one word into the next. The sequencer keeps the program counter and a two-bit slot pointer that says which 15-bit parcel of the held word comes next. It fetches a word only once that word is used up. It presents one instruction per cycle, already split into opcode, I, J and K fields. Executing the instructions is left to the stages behind it.

A redirect port replaces the program counter and restarts at the top of the target word, so the execution stage uses it for every taken branch. The sequencer halts for good in three cases: on the stop opcode, on an attempt to run location zero, and on an address at or above the configured memory size. The halt cause stays visible on a two-bit code until reset. Opcode 03 picks one of eight test variants from its I field, and the block sends that variant out as a one-hot vector.

Top module: `psq_sequencer`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `halted` are 0 and `halt_cause` is 0. The first fetch request after release is for address START_ADDR, which defaults to 1.
- R2: Slots are used from the most significant end. Slot s (0..3) starts at bit 59-15*s. `out_slot` and `out_pc` give the slot and the word address of the instruction on show.
- R3: An instruction is 30 bits long when its opcode is octal 01-07, 50-52, 60-62 or 70-72, and 15 bits long otherwise. `out_long` shows the length. The opcode is the top 6 bits of the instruction. I is the next 3 bits and J the 3 bits after that. K is the rest: 3 bits for a short instruction and 18 bits for a long one, zero-extended to 18 bits.
- R4: Each word is fetched once. The next word is fetched only after the last instruction of the held word has been shown, and a fetched word is taken from slot 0.
- R5: A 30-bit instruction found at slot 3 is not shown. The sequencer moves to the next word address and fetches it.
- R6: When the program counter is zero at fetch time, no request is made and the block halts with `halt_cause` = 2.
- R7: When the program counter is at or above MEM_WORDS at fetch time, no request is made and the block halts with `halt_cause` = 3.
- R8: An instruction with opcode 00 is shown, and in the next cycle the block halts with `halt_cause` = 1. Any instruction after it in the same word is not shown. A halted block shows nothing, requests nothing and ignores redirects until reset.
- R9: `out_xtest` is the one-hot value 1<<I when the opcode is 03, and zero for any other opcode.
- R10: A redirect in any non-halted cycle takes priority over everything else in that cycle. The next fetch is for the redirect address, and the target word is taken from slot 0. The instruction on show in the redirect cycle counts as issued.
- R11: A word is accepted in a cycle where `fetch_req` and `fetch_valid` are both high. While a request waits, `fetch_addr` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | output | 1 | Word fetch request |
| fetch_addr | output | AW | Word address of the request |
| fetch_valid | input | 1 | Memory delivers `fetch_word` this cycle |
| fetch_word | input | 60 | Fetched instruction word |
| redir_valid | input | 1 | Branch redirect strobe |
| redir_addr | input | AW | Redirect target word address |
| out_valid | output | 1 | An instruction is shown this cycle |
| out_opcode | output | 6 | Opcode field |
| out_i | output | 3 | I field |
| out_j | output | 3 | J field |
| out_k | output | 18 | K field, zero-extended when short |
| out_long | output | 1 | Instruction is 30 bits long |
| out_xtest | output | 8 | One-hot test variant for opcode 03 |
| out_pc | output | AW | Word address of the instruction |
| out_slot | output | 2 | Starting slot of the instruction |
| halted | output | 1 | Sequencer stopped |
| halt_cause | output | 2 | 0 none, 1 stop, 2 location zero, 3 out of bounds |

## Verification
The first program mixes short and long instructions in every slot arrangement, including a word of four short ones and a test-jump opcode with several I values. It shows whether the slot pointer steps by the right length and whether the fields are cut at the right bits. A second program puts a long opcode in slot 3 and runs with a memory that grants only one cycle in three. This separates a correct skip to the next word from a wrong issue, and it shows whether the request address holds steady while the block waits. Redirects into a run that ends above the memory limit, and into location zero, tell the two fault causes apart. A final redirect sent after the halt shows whether the halt really ignores it.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int WORD_W   = 60;
  localparam int PARCEL_W = 15;
  localparam int SLOTS    = WORD_W / PARCEL_W;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int OP_W     = 6;
  localparam int F_W      = 3;
  localparam int K_W      = 2 * PARCEL_W - OP_W - 2 * F_W;
  localparam int XT_W     = 1 << F_W;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_ISSUE = 2'd1,
    ST_HALT  = 2'd2
  } seq_state_t;

  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_STOP  = 2'd1;
  localparam logic [1:0] CAUSE_ZERO  = 2'd2;
  localparam logic [1:0] CAUSE_BOUND = 2'd3;

  localparam logic [OP_W-1:0] OP_STOP  = 6'o00;
  localparam logic [OP_W-1:0] OP_XTEST = 6'o03;

  function automatic logic op_is_long(input logic [OP_W-1:0] op);
    case (op)
      6'o01, 6'o02, 6'o03, 6'o04, 6'o05, 6'o06, 6'o07,
      6'o50, 6'o51, 6'o52, 6'o60, 6'o61, 6'o62,
      6'o70, 6'o71, 6'o72: op_is_long = 1'b1;
      default:             op_is_long = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/psq_extract.sv
module psq_extract
  import psq_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [OP_W-1:0]   op_o,
  output logic [F_W-1:0]    i_o,
  output logic [F_W-1:0]    j_o,
  output logic [K_W-1:0]    k_o,
  output logic              long_o,
  output logic              fits_o,
  output logic [XT_W-1:0]   xtest_o
);
  localparam int EXT_W = WORD_W + PARCEL_W;
  localparam int WIN_W = 2 * PARCEL_W;
  localparam int SHORT_K = PARCEL_W - OP_W - 2 * F_W;

  logic [EXT_W-1:0] ext;
  logic [WIN_W-1:0] win [SLOTS];
  logic [WIN_W-1:0] sel;

  assign ext = {word_i, {PARCEL_W{1'b0}}};

  for (genvar s = 0; s < SLOTS; s++) begin : g_win
    assign win[s] = ext[EXT_W-1-PARCEL_W*s -: WIN_W];
  end

  assign sel    = win[slot_i];
  assign op_o   = sel[WIN_W-1 -: OP_W];
  assign i_o    = sel[WIN_W-1-OP_W -: F_W];
  assign j_o    = sel[WIN_W-1-OP_W-F_W -: F_W];
  assign long_o = op_is_long(op_o);
  assign fits_o = !(long_o && (slot_i == SLOT_W'(SLOTS - 1)));

  always_comb begin
    if (long_o) k_o = sel[K_W-1:0];
    else        k_o = {{(K_W-SHORT_K){1'b0}}, sel[K_W-1 -: SHORT_K]};
  end

  always_comb begin
    xtest_o = '0;
    if (op_o == OP_XTEST) xtest_o[i_o] = 1'b1;
  end
endmodule

// File: rtl/psq_guard.sv
module psq_guard #(
  parameter int AW        = 18,
  parameter int MEM_WORDS = 4096
) (
  input  logic [AW-1:0] pc_i,
  output logic          bad_zero_o,
  output logic          bad_bound_o
);
  localparam logic [AW-1:0] LIMIT = AW'(MEM_WORDS);

  assign bad_zero_o  = (pc_i == '0);
  assign bad_bound_o = (pc_i >= LIMIT);
endmodule

// File: rtl/psq_sequencer.sv
module psq_sequencer
  import psq_pkg::*;
#(
  parameter int AW         = 18,
  parameter int MEM_WORDS  = 4096,
  parameter int START_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fetch_req,
  output logic [AW-1:0]     fetch_addr,
  input  logic              fetch_valid,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              redir_valid,
  input  logic [AW-1:0]     redir_addr,
  output logic              out_valid,
  output logic [OP_W-1:0]   out_opcode,
  output logic [F_W-1:0]    out_i,
  output logic [F_W-1:0]    out_j,
  output logic [K_W-1:0]    out_k,
  output logic              out_long,
  output logic [XT_W-1:0]   out_xtest,
  output logic [AW-1:0]     out_pc,
  output logic [SLOT_W-1:0] out_slot,
  output logic              halted,
  output logic [1:0]        halt_cause
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  seq_state_t        state_q, state_d;
  logic [AW-1:0]     pc_q, pc_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [1:0]        cause_q, cause_d;
  logic              st_en, pc_en, slot_en, word_en, cause_en;

  logic              fits, is_long, bad_zero, bad_bound;
  logic [SLOT_W:0]   slot_sum;

  psq_extract u_extract (
    .word_i (word_q),
    .slot_i (slot_q),
    .op_o   (out_opcode),
    .i_o    (out_i),
    .j_o    (out_j),
    .k_o    (out_k),
    .long_o (is_long),
    .fits_o (fits),
    .xtest_o(out_xtest)
  );

  psq_guard #(.AW(AW), .MEM_WORDS(MEM_WORDS)) u_guard (
    .pc_i       (pc_q),
    .bad_zero_o (bad_zero),
    .bad_bound_o(bad_bound)
  );

  assign slot_sum   = {1'b0, slot_q} + (is_long ? (SLOT_W+1)'(2) : (SLOT_W+1)'(1));
  assign fetch_req  = rst_int_n && (state_q == ST_FETCH) && !bad_zero && !bad_bound;
  assign fetch_addr = pc_q;
  assign out_valid  = (state_q == ST_ISSUE) && fits;
  assign out_long   = is_long;
  assign out_pc     = pc_q;
  assign out_slot   = slot_q;
  assign halted     = (state_q == ST_HALT);
  assign halt_cause = cause_q;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    slot_d   = slot_q;
    word_d   = word_q;
    cause_d  = cause_q;
    st_en    = 1'b0;
    pc_en    = 1'b0;
    slot_en  = 1'b0;
    word_en  = 1'b0;
    cause_en = 1'b0;
    case (state_q)
      ST_FETCH: begin
        if (bad_zero) begin
          state_d = ST_HALT;  st_en = 1'b1;
          cause_d = CAUSE_ZERO; cause_en = 1'b1;
        end else if (bad_bound) begin
          state_d = ST_HALT;  st_en = 1'b1;
          cause_d = CAUSE_BOUND; cause_en = 1'b1;
        end else if (fetch_valid) begin
          word_d  = fetch_word; word_en = 1'b1;
          slot_d  = '0;         slot_en = 1'b1;
          state_d = ST_ISSUE;   st_en   = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (!fits || (out_opcode != OP_STOP && slot_sum[SLOT_W])) begin
          pc_d    = pc_q + AW'(1); pc_en = 1'b1;
          state_d = ST_FETCH;      st_en = 1'b1;
        end else if (out_opcode == OP_STOP) begin
          state_d = ST_HALT;    st_en = 1'b1;
          cause_d = CAUSE_STOP; cause_en = 1'b1;
        end else begin
          slot_d  = slot_sum[SLOT_W-1:0]; slot_en = 1'b1;
        end
      end
      default: ;
    endcase
    if (redir_valid && state_q != ST_HALT) begin
      pc_d     = redir_addr; pc_en = 1'b1;
      state_d  = ST_FETCH;   st_en = 1'b1;
      word_en  = 1'b0;
      slot_en  = 1'b0;
      cause_en = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_FETCH;
      pc_q    <= AW'(START_ADDR);
      slot_q  <= '0;
      word_q  <= '0;
      cause_q <= CAUSE_NONE;
    end else begin
      if (st_en)    state_q <= state_d;
      if (pc_en)    pc_q    <= pc_d;
      if (slot_en)  slot_q  <= slot_d;
      if (word_en)  word_q  <= word_d;
      if (cause_en) cause_q <= cause_d;
    end
  end

  // assertions
  AST_NEW_WORD_TOP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fetch_req && fetch_valid && !redir_valid) |=> (out_slot == '0) && !fetch_req); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fetch_req && !fetch_valid && !redir_valid) |=> fetch_req && $stable(fetch_addr)); // R11
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_opcode == OP_STOP && !redir_valid) |=> halted && halt_cause == CAUSE_STOP); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    halted |=> halted && !out_valid && !fetch_req && $stable(out_pc)); // R8
  AST_REDIR_RESTART: assert property (@(posedge clk) disable iff (!rst_int_n)
    (redir_valid && !halted) |=> !out_valid && out_pc == $past(redir_addr)); // R10
  AST_XTEST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> $onehot0(out_xtest) && ((out_opcode == OP_XTEST) == (out_xtest != '0))); // R9
  AST_LONG_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_long) |-> out_slot != SLOT_W'(SLOTS - 1)); // R5
endmodule

// File: tb/tb_psq_sequencer.sv
`timescale 1ns/1ps
module tb_psq_sequencer;
  localparam int LIM = 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req, fetch_valid, redir_valid;
  logic [17:0] fetch_addr, redir_addr;
  logic [59:0] fetch_word;
  logic        out_valid, out_long, halted;
  logic [5:0]  out_opcode;
  logic [2:0]  out_i, out_j;
  logic [17:0] out_k, out_pc;
  logic [7:0]  out_xtest;
  logic [1:0]  out_slot, halt_cause;
  logic        gnt;

  logic [59:0] mem [0:63];

  always #2 clk = ~clk;

  assign fetch_valid = fetch_req && gnt;
  assign fetch_word  = mem[fetch_addr[5:0]];

  psq_sequencer #(.AW(18), .MEM_WORDS(LIM), .START_ADDR(1)) dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .out_valid(out_valid), .out_opcode(out_opcode), .out_i(out_i), .out_j(out_j),
    .out_k(out_k), .out_long(out_long), .out_xtest(out_xtest), .out_pc(out_pc),
    .out_slot(out_slot), .halted(halted), .halt_cause(halt_cause)
  );

  int checks = 0;
  int errors = 0;
  logic [49:0] expq [$];
  int exp_cause, exp_words;
  int issued, fetches, cyc;
  bit bad_fetch, first_seen, prev_wait, prev_redir;
  logic [17:0] prev_addr;

  function automatic logic [14:0] sh(input logic [5:0] op, input logic [2:0] i,
                                     input logic [2:0] j, input logic [2:0] k);
    return {op, i, j, k};
  endfunction

  function automatic logic [29:0] lg(input logic [5:0] op, input logic [2:0] i,
                                     input logic [2:0] j, input logic [17:0] k);
    return {op, i, j, k};
  endfunction

  function automatic bit ref_long(input logic [5:0] op);
    int hi = op / 8;
    int lo = op % 8;
    return (op >= 1 && op <= 7) || (hi >= 5 && lo <= 2);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural walk of the program from a start address
  task automatic walk(input int start);
    int pc = start;
    exp_words = 0;
    exp_cause = 0;
    for (int guard = 0; guard < 64; guard++) begin
      logic [59:0] w;
      bit stop = 0;
      if (pc == 0) begin exp_cause = 2; break; end
      if (pc >= LIM) begin exp_cause = 3; break; end
      w = mem[pc];
      exp_words++;
      for (int p = 0; p < 4; ) begin
        logic [5:0] op = w[59-15*p -: 6];
        logic [29:0] ins;
        logic [17:0] k;
        bit lng = ref_long(op);
        if (lng && p == 3) break;
        if (lng) ins = w[59-15*p -: 30];
        else     ins = {w[59-15*p -: 15], 15'b0};
        k = lng ? ins[17:0] : {15'b0, ins[17:15]};
        expq.push_back({18'(pc), 2'(p), op, ins[23:21], ins[20:18], k});
        if (op == 6'o00) begin stop = 1; break; end
        p += lng ? 2 : 1;
      end
      if (stop) begin exp_cause = 1; break; end
      pc++;
    end
  endtask

  // one cycle: compare at negedge, then drive the next cycle's inputs
  task automatic step(input bit stall, input int redir_n, input int redir_tgt,
                      inout bit redir_done);
    logic [49:0] act, exp;
    @(negedge clk);
    cyc++;
    if (prev_wait && !prev_redir)
      check(fetch_req && fetch_addr == prev_addr, "R11", "held request address",
            fetch_addr, prev_addr);
    if (fetch_req && !first_seen) begin
      first_seen = 1;
      check(fetch_addr == 18'd1, "R1", "first fetch address", fetch_addr, 1);
    end
    if (fetch_req && (fetch_addr == 0 || fetch_addr >= LIM)) bad_fetch = 1;
    if (out_valid) begin
      act = {out_pc, out_slot, out_opcode, out_i, out_j, out_k};
      if (expq.size() == 0) begin
        check(0, "R8", "instruction shown after end of program", act, 0);
      end else begin
        exp = expq.pop_front();
        check(act == exp, "R2/R3", "pc,slot,op,i,j,k", act, exp);
        check(out_long == ref_long(out_opcode), "R3", "length flag", out_long,
              ref_long(out_opcode));
        check(out_xtest == ((out_opcode == 6'o03) ? (8'd1 << out_i) : 8'd0), "R9",
              "test variant", out_xtest, (out_opcode == 6'o03) ? (8'd1 << out_i) : 8'd0);
      end
      issued++;
    end
    gnt = stall ? (cyc % 3 == 2) : 1'b1;
    redir_valid = 1'b0;
    if (redir_n >= 0 && !redir_done && issued == redir_n) begin
      redir_done  = 1;
      redir_valid = 1'b1;
      redir_addr  = 18'(redir_tgt);
      expq.delete();
      walk(redir_tgt);
    end
    #1;
    if (fetch_req && fetch_valid) fetches++;
    prev_wait  = fetch_req && !fetch_valid;
    prev_redir = redir_valid;
    prev_addr  = fetch_addr;
  endtask

  task automatic run_phase(input bit stall, input int redir_n, input int redir_tgt,
                           input bit count_words);
    bit rdone = 0;
    int words0;
    rst_n = 1'b0;
    redir_valid = 1'b0;
    redir_addr = '0;
    gnt = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid && !halted && halt_cause == 0 && !fetch_req, "R1", "reset state",
          {out_valid, halted, halt_cause, fetch_req}, 0);
    expq.delete();
    walk(1);
    words0 = exp_words;
    issued = 0; fetches = 0; cyc = 0;
    bad_fetch = 0; first_seen = 0; prev_wait = 0; prev_redir = 0;
    rst_n = 1'b1;
    for (int n = 0; n < 3000 && !halted; n++) step(stall, redir_n, redir_tgt, rdone);
    check(halted && halt_cause == 2'(exp_cause), "R6/R7/R8", "halt cause",
          {halted, halt_cause}, {1'b1, 2'(exp_cause)});
    check(expq.size() == 0, "R4", "instructions left unshown", expq.size(), 0);
    check(!bad_fetch, "R6/R7", "request to a faulting address", bad_fetch, 0);
    if (count_words) check(fetches == words0, "R4", "word fetch count", fetches, words0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit dummy;
    for (int a = 0; a < 64; a++) mem[a] = {4{sh(6'o46, 3'd0, 3'd0, 3'd0)}};

    // P1: mixed lengths, four shorts, test jumps, stop in slot 2 (R2 R3 R4 R8 R9)
    mem[1] = {sh(6'o10, 3'd1, 3'd2, 3'd3), sh(6'o36, 3'd4, 3'd5, 3'd6),
              lg(6'o50, 3'd1, 3'd2, 18'h2ABCD)};
    mem[2] = {lg(6'o03, 3'd5, 3'd1, 18'h00123), lg(6'o71, 3'd7, 3'd6, 18'h3FFFF)};
    mem[3] = {sh(6'o11, 3'd7, 3'd0, 3'd1), sh(6'o47, 3'd2, 3'd3, 3'd7),
              sh(6'o21, 3'd6, 3'd6, 3'd5), sh(6'o12, 3'd0, 3'd7, 3'd2)};
    mem[4] = {lg(6'o03, 3'd0, 3'd2, 18'h00005), sh(6'o00, 3'd0, 3'd0, 3'd0),
              sh(6'o46, 3'd1, 3'd1, 3'd1)};
    run_phase(0, -1, 0, 1);

    // P2: long opcode at slot 3 is skipped, stalled memory (R5 R11)
    mem[1] = {sh(6'o10, 3'd1, 3'd1, 3'd1), sh(6'o11, 3'd2, 3'd2, 3'd2),
              sh(6'o12, 3'd3, 3'd3, 3'd3), sh(6'o02, 3'd4, 3'd4, 3'd4)};
    mem[2] = {lg(6'o04, 3'd1, 3'd2, 18'h11111), sh(6'o13, 3'd5, 3'd5, 3'd5),
              sh(6'o03, 3'd6, 3'd6, 3'd6)};
    mem[3] = {sh(6'o17, 3'd2, 3'd4, 3'd6), lg(6'o61, 3'd3, 3'd0, 18'h20001),
              sh(6'o00, 3'd0, 3'd0, 3'd0)};
    run_phase(1, -1, 0, 1);

    // P3: redirect mid-word, then run off the memory limit (R10 R7)
    mem[1] = {4{sh(6'o14, 3'd1, 3'd2, 3'd3)}};
    mem[2] = {4{sh(6'o15, 3'd3, 3'd2, 3'd1)}};
    mem[45] = {lg(6'o72, 3'd2, 3'd3, 18'h0BEEF), lg(6'o51, 3'd1, 3'd0, 18'h00042)};
    mem[46] = {4{sh(6'o22, 3'd4, 3'd4, 3'd4)}};
    mem[47] = {lg(6'o60, 3'd5, 3'd5, 18'h12345), sh(6'o20, 3'd1, 3'd1, 3'd1),
               sh(6'o43, 3'd6, 3'd0, 3'd7)};
    run_phase(0, 3, 45, 0);

    // P4: redirect to location zero (R6), then a redirect while halted is ignored (R8)
    run_phase(0, 2, 0, 0);
    @(negedge clk);
    redir_valid = 1'b1;
    redir_addr  = 18'd5;
    @(negedge clk);
    redir_valid = 1'b0;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check(halted && !fetch_req && !out_valid && out_pc == 18'd0 && halt_cause == 2'd2,
            "R8", "halt ignores redirect", {halted, fetch_req, out_valid, out_pc},
            {1'b1, 1'b0, 1'b0, 18'd0});
    end
    dummy = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule